// File: doc/BRIEF.md
# Expansion-Bus Master Cycle Sequencer

This block drives the master side of one cycle on a 32-bit expansion bus of the Extended ISA style. A single bus clock is used on both edges. The rising edges advance the sequencer, capture the slave's width strobes and capture the burst offer. The falling edges sample the slave's ready line and update the burst request output. A local requester raises `req` for one clock with a transfer count. The block then runs the strobe phase and the command phase, inserts wait states for as long as the slave holds ready high, and reports completion with a one-clock `done` pulse.

If the slave offers a burst and the count is two or more, the block requests a burst and runs the whole count as back-to-back transfers, one for each ready sample. It withdraws the request in time for the final transfer. Otherwise only one transfer runs.

The states are IDLE, STROBE, COMMAND and FINISH. Their transitions are:
- IDLE to STROBE when `req` is seen.
- STROBE to COMMAND unconditionally.
- COMMAND to COMMAND on a wait state or on a non-final completed transfer.
- COMMAND to FINISH on completion of the final transfer.
- FINISH to IDLE unconditionally.

Top module: `bus_master_seq`

## Requirements
- R1: While `rst_n` is low, `bus_strobe_n` and `bus_cmd_n` are high, `done` is 0 and `burst_oe` is 0. After reset is released, `burst_oe` goes to 1 with `burst_n` high.
- R2: `bus_strobe_n` goes low on the rising edge after `req` is seen in IDLE, and stays low for exactly one clock.
- R3: `bus_cmd_n` goes low on the same rising edge on which `bus_strobe_n` returns high.
- R4: On the rising edge where the strobe is released, the block latches the slave width. The code is 2'b10 (32-bit) when `slave_w32_n` is low. It is 2'b01 (16-bit) when only `slave_w16_n` is low. It is 2'b00 (8-bit) when both are high. The code holds until the next cycle's capture.
- R5: `slave_ready_n` is sampled on each falling edge during the command phase. Each high sample adds one clock of wait, and the command stays asserted through the wait.
- R6: If `slave_burst_n` is low on the strobe-release edge and `xfer_count` is 2 or more, `burst_n` goes low from the next falling edge. The cycle then runs `xfer_count` transfers, each completed by one low ready sample.
- R7: `burst_n` returns high on the falling edge inside the final transfer of a burst. Without a burst offer, or with `xfer_count` below 2, exactly one transfer runs and `burst_n` stays high.
- R8: `done` is high for exactly one clock, in the cycle after the final transfer completes, with `bus_cmd_n` already high. A count of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, both edges used |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Start request, seen in IDLE |
| xfer_count | input | CNT_W | Transfers wanted in a burst |
| done | output | 1 | One-clock completion pulse |
| width_code | output | 2 | Latched slave width code |
| bus_strobe_n | output | 1 | Active-low cycle strobe |
| bus_cmd_n | output | 1 | Active-low command |
| burst_n | output | 1 | Active-low burst request (falling-edge driven) |
| burst_oe | output | 1 | Drive enable for `burst_n`, 0 in reset |
| slave_ready_n | input | 1 | Active-low slave ready (pulled up) |
| slave_w32_n | input | 1 | Active-low 32-bit support (pulled up) |
| slave_w16_n | input | 1 | Active-low 16-bit support (pulled up) |
| slave_burst_n | input | 1 | Active-low slave burst offer (pulled up) |

## Verification
The strobe is due one rising edge after `req` is taken. The command and the width code are due one edge after that. The burst request appears half a clock later, at the falling edge. `done` follows one rising edge after the falling edge that saw ready low. The bench changes slave inputs 2 ns after a rising edge, before the falling edge that samples them, and reads outputs 6 ns after the rising edge, after both edges of that clock have acted. Each scenario then steps clock by clock, predicting wait, burst and completion from its own count and wait settings.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_STROBE = 2'd1,
        S_CMD    = 2'd2,
        S_FINISH = 2'd3
    } seq_state_t;

    localparam logic [1:0] WIDTH_8  = 2'b00;
    localparam logic [1:0] WIDTH_16 = 2'b01;
    localparam logic [1:0] WIDTH_32 = 2'b10;

endpackage

// File: rtl/bus_width_capture.sv
module bus_width_capture
    import bus_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic       w32_n,
    input  logic       w16_n,
    output logic [1:0] width_code
);

    logic [1:0] code_next;

    always_comb begin
        if (!w32_n)
            code_next = WIDTH_32;
        else if (!w16_n)
            code_next = WIDTH_16;
        else
            code_next = WIDTH_8;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            width_code <= WIDTH_8;
        else if (capture)
            width_code <= code_next;
    end

    // R4: code only moves on a capture edge
    assert_width_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(width_code));

endmodule

// File: rtl/bus_ready_sampler.sv
module bus_ready_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic ready_n,
    output logic ready_seen
);

    // R5: falling-edge sample of the slave ready line
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            ready_seen <= 1'b0;
        else
            ready_seen <= sample_en & ~ready_n;
    end

endmodule

// File: rtl/bus_burst_tracker.sv
module bus_burst_tracker #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             offer,
    input  logic [CNT_W-1:0] count,
    input  logic             xfer_done,
    output logic             last_xfer,
    output logic             burst_n,
    output logic             burst_oe
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0] remaining;
    logic             active;
    logic             burst_q;
    logic             oe_q;
    logic             accept;

    assign accept    = offer && (count >= TWO);
    assign last_xfer = (remaining <= ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining <= ONE;
            active    <= 1'b0;
        end else if (load) begin
            remaining <= accept ? count : ONE;
            active    <= accept;
        end else if (xfer_done && !last_xfer) begin
            remaining <= remaining - ONE;
            if (remaining == TWO)
                active <= 1'b0;
        end
    end

    // R6, R7: the request line follows the tracker on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_q <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            burst_q <= active;
            oe_q    <= 1'b1;
        end
    end

    assign burst_n  = ~burst_q;
    assign burst_oe = oe_q;

    // R7: a burst is never left running into its final transfer
    assert_burst_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && remaining == TWO) |=> !active);

endmodule

// File: rtl/bus_master_seq.sv
module bus_master_seq
    import bus_seq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] xfer_count,
    output logic             done,
    output logic [1:0]       width_code,
    output logic             bus_strobe_n,
    output logic             bus_cmd_n,
    output logic             burst_n,
    output logic             burst_oe,
    input  logic             slave_ready_n,
    input  logic             slave_w32_n,
    input  logic             slave_w16_n,
    input  logic             slave_burst_n
);

    seq_state_t state, state_next;
    logic       ready_seen;
    logic       last_xfer;
    logic       xfer_done;
    logic       in_strobe;
    logic       in_cmd;

    assign in_strobe = (state == S_STROBE);
    assign in_cmd    = (state == S_CMD);
    assign xfer_done = in_cmd && ready_seen;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_next;
    end

    // transitions
    always_comb begin
        state_next = state;
        unique case (state)
            S_IDLE:   if (req) state_next = S_STROBE;
            S_STROBE: state_next = S_CMD;
            S_CMD:    if (xfer_done && last_xfer) state_next = S_FINISH;
            S_FINISH: state_next = S_IDLE;
            default:  state_next = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_strobe_n = 1'b1;
        bus_cmd_n    = 1'b1;
        done         = 1'b0;
        unique case (state)
            S_IDLE:   ;
            S_STROBE: bus_strobe_n = 1'b0;
            S_CMD:    bus_cmd_n    = 1'b0;
            S_FINISH: done         = 1'b1;
            default:  ;
        endcase
    end

    bus_width_capture u_width (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (in_strobe),
        .w32_n      (slave_w32_n),
        .w16_n      (slave_w16_n),
        .width_code (width_code)
    );

    bus_ready_sampler u_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (in_cmd),
        .ready_n    (slave_ready_n),
        .ready_seen (ready_seen)
    );

    bus_burst_tracker #(.CNT_W(CNT_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (in_strobe),
        .offer     (~slave_burst_n),
        .count     (xfer_count),
        .xfer_done (xfer_done),
        .last_xfer (last_xfer),
        .burst_n   (burst_n),
        .burst_oe  (burst_oe)
    );

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_strobe_n) |=> $rose(bus_strobe_n));

    assert_cmd_on_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_strobe_n) |-> !bus_cmd_n);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_cmd_n && $past(!bus_cmd_n)));

    assert_no_burst_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> burst_n);

endmodule

// File: tb/bus_master_seq_test.sv
module bus_master_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [3:0] xfer_count = 4'd1;
    logic       done;
    logic [1:0] width_code;
    logic       bus_strobe_n, bus_cmd_n, burst_n, burst_oe;
    logic       slave_ready_n = 1'b1;
    logic       slave_w32_n = 1'b1;
    logic       slave_w16_n = 1'b1;
    logic       slave_burst_n = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bus_master_seq #(.CNT_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .xfer_count(xfer_count),
        .done(done), .width_code(width_code),
        .bus_strobe_n(bus_strobe_n), .bus_cmd_n(bus_cmd_n),
        .burst_n(burst_n), .burst_oe(burst_oe),
        .slave_ready_n(slave_ready_n), .slave_w32_n(slave_w32_n),
        .slave_w16_n(slave_w16_n), .slave_burst_n(slave_burst_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One full cycle. Entered and left 6 ns after a rising edge.
    task automatic do_cycle(input int n, input bit sb, input int waits,
                            input bit w32n, input bit w16n);
        int eff;
        logic [1:0] ew;
        bit first;
        eff = (sb && n > 1) ? n : 1;
        ew = !w32n ? 2'b10 : (!w16n ? 2'b01 : 2'b00);
        first = 1'b1;
        slave_w32_n = w32n; slave_w16_n = w16n; slave_burst_n = !sb;
        slave_ready_n = 1'b1; xfer_count = 4'(n); req = 1'b1;
        @(posedge clk); #2 req = 1'b0;
        #4;
        chk(bus_strobe_n == 1'b0, "R2 strobe low", bus_strobe_n, 0);
        chk(bus_cmd_n == 1'b1, "R3 cmd high during strobe", bus_cmd_n, 1);
        @(posedge clk); #2;
        slave_w32_n = !w32n; slave_w16_n = !w16n; slave_burst_n = sb;
        for (int t = 0; t < eff; t++) begin
            for (int w = 0; w <= waits; w++) begin
                if (!first) begin
                    @(posedge clk); #2;
                end
                slave_ready_n = (w < waits);
                #4;
                if (first) begin
                    chk(bus_strobe_n == 1'b1, "R2 strobe one clock", bus_strobe_n, 1);
                    chk(bus_cmd_n == 1'b0, "R3 cmd on release", bus_cmd_n, 0);
                    chk(width_code == ew, "R4 width latched", width_code, ew);
                end
                first = 1'b0;
                chk(bus_cmd_n == 1'b0, "R5 cmd held", bus_cmd_n, 0);
                chk(done == 1'b0, "R8 no early done", done, 0);
                chk(burst_n == !(eff > 1 && (eff - t) >= 2), "R6 R7 burst line",
                    burst_n, !(eff > 1 && (eff - t) >= 2));
            end
        end
        @(posedge clk); #2 slave_ready_n = 1'b1;
        #4;
        chk(done == 1'b1, "R8 done", done, 1);
        chk(bus_cmd_n == 1'b1, "R8 cmd released", bus_cmd_n, 1);
        chk(burst_n == 1'b1, "R7 burst off at end", burst_n, 1);
        chk(width_code == ew, "R4 width held", width_code, ew);
        @(posedge clk); #6;
        chk(done == 1'b0, "R8 done one clock", done, 0);
        chk(bus_strobe_n == 1'b1, "R2 idle strobe", bus_strobe_n, 1);
    endtask

    task automatic test_reset();
        #3;
        chk(bus_strobe_n == 1'b1, "R1 strobe in reset", bus_strobe_n, 1);
        chk(bus_cmd_n == 1'b1, "R1 cmd in reset", bus_cmd_n, 1);
        chk(done == 1'b0, "R1 done in reset", done, 0);
        chk(burst_oe == 1'b0, "R1 burst tri-state", burst_oe, 0);
        @(posedge clk); @(posedge clk); #2 rst_n = 1'b1;
        @(posedge clk); #6;
        chk(burst_oe == 1'b1, "R1 burst driven", burst_oe, 1);
        chk(burst_n == 1'b1, "R1 burst idle", burst_n, 1);
    endtask

    task automatic test_single_w32();  do_cycle(1, 1'b0, 0, 1'b0, 1'b1); endtask
    task automatic test_waits_w16();   do_cycle(1, 1'b0, 2, 1'b1, 1'b0); endtask
    task automatic test_refused_w8();  do_cycle(3, 1'b0, 0, 1'b1, 1'b1); endtask
    task automatic test_burst4();      do_cycle(4, 1'b1, 0, 1'b0, 1'b0); endtask
    task automatic test_burst_waits(); do_cycle(3, 1'b1, 1, 1'b1, 1'b0); endtask
    task automatic test_burst_one();   do_cycle(1, 1'b1, 1, 1'b0, 1'b1); endtask
    task automatic test_count_zero();  do_cycle(0, 1'b1, 0, 1'b1, 1'b0); endtask

    initial begin
        test_reset();
        test_single_w32();
        test_waits_w16();
        test_refused_w8();
        test_burst4();
        test_burst_waits();
        test_burst_one();
        test_count_zero();
        finished = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule